// File: doc/BRIEF.md
# Per-Core Private Event Timer

This block is a timer owned by a single processor core. Software reaches it through a small indexed register port rather than through a memory map. Each access gives a register index, a write strobe and write data, and the read data follows in the same cycle. The timer has two jobs. It keeps a free-running tick count that software can read as a timestamp. It also raises one private interrupt a programmed number of ticks after software writes the next-event delta.

The event path is a relative one-shot. Software first sets the enable bit. From then on, each write of a delta restarts the countdown, and no other register has to be touched. When the countdown expires, the pending bit is set and the countdown stops. The interrupt line shows the pending bit for as long as the enable bit is set. Software acknowledges an event by writing zero to the status register.

Top module: `core_evt_timer`

## Requirements
- R1: After reset, the enable bit, the pending bit, the load register, the tick count and the interrupt output are all zero.
- R2: Index 0 holds the enable in bit 0, index 1 holds the pending flag in bit 0, index 3 gives the tick count and index 6 gives the last value written as the delta. Any other index reads zero, and writes to other indices change nothing.
- R3: The tick count rises by one on every clock whatever the enable bit holds, wraps from all ones to zero, and ignores writes.
- R4: With the enable bit set, writing a delta d of at least 1 to index 6 makes the pending bit and the interrupt go high exactly d clocks after the write edge.
- R5: A new delta written while a countdown runs replaces it, and the new delta is timed from its own write edge.
- R6: A delta written while the enable bit is clear is stored but arms nothing, so setting the enable bit later raises no event. Clearing the enable bit cancels a running countdown.
- R7: Writing a delta of zero cancels any running countdown and schedules no event.
- R8: The interrupt is high exactly when both the pending bit and the enable bit are set. The pending bit survives a clear of the enable bit.
- R9: Writing index 1 with bit 0 equal to 0 clears the pending bit, and writing it with bit 0 equal to 1 is ignored. An expiry in the same cycle as a clear leaves the pending bit set.
- R10: After an event fires, the countdown stays stopped. No further event occurs until the next delta write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 3 | Register index |
| we_i | input | 1 | Write strobe for the indexed register |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data of the indexed register, combinational |
| irq_o | output | 1 | Private interrupt line |

## Verification
The bench runs a small 8-bit configuration. It sweeps every delta from 1 to 40 and also tries the largest delta. For each delta it checks that the interrupt is still low one clock before the predicted edge and high on that edge, which exposes off-by-one errors in the countdown.

Further patterns each target one separate fault:
- a reload part-way through a countdown;
- a delta written while disabled;
- a disable part-way through a countdown;
- a zero delta;
- a clear that lands on the expiry edge;
- a long idle stretch after an event.

These patterns separate restart, arming, cancel, priority and re-fire faults. The tick count is compared with an arithmetic model across several wraps, so a stall, a skip or a stray write shows up.

// File: rtl/ptim_pkg.sv
package ptim_pkg;
  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_TICK = 3'd3;
  localparam logic [IDX_W-1:0] IDX_LOAD = 3'd6;
endpackage

// File: rtl/ptim_free_cnt.sv
module ptim_free_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] tick_o
);
  logic [CNT_W-1:0] tick_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign tick_o = tick_q;

  // R3
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> tick_q == $past(tick_q) + 1'b1);
endmodule

// File: rtl/ptim_evt_unit.sv
module ptim_evt_unit #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_we_i) begin
      cnt_q   <= load_val_i;
      armed_q <= en_i && (load_val_i != '0);
    end else if (armed_q && en_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == ONE) armed_q <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
    end
  end

  assign fire_o = armed_q && en_i && !load_we_i && (cnt_q == ONE);

  // R4
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && en_i && !load_we_i && cnt_q > ONE) |=> (armed_q && cnt_q == $past(cnt_q) - 1'b1));
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> cnt_q == $past(load_val_i));
  // R6
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> !armed_q);
  // R10
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
endmodule

// File: rtl/ptim_regs.sv
module ptim_regs
  import ptim_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] tick_i,
  input  logic             fire_i,
  output logic             en_o,
  output logic             load_we_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic             en_q, pend_q;
  logic [CNT_W-1:0] load_q;
  logic             wr_ctrl, wr_stat, wr_load;

  always_comb begin
    wr_ctrl = we_i && (idx_i == IDX_CTRL);
    wr_stat = we_i && (idx_i == IDX_STAT);
    wr_load = we_i && (idx_i == IDX_LOAD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[0];
      if (wr_load) load_q <= wdata_i;
      // expiry outranks a same-cycle clear
      if (fire_i)                      pend_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      IDX_CTRL: rdata_o[0] = en_q;
      IDX_STAT: rdata_o[0] = pend_q;
      IDX_TICK: rdata_o    = tick_i;
      IDX_LOAD: rdata_o    = load_q;
      default:  rdata_o    = '0;
    endcase
  end

  assign en_o       = en_q;
  assign load_we_o  = wr_load;
  assign load_val_o = wdata_i;
  assign irq_o      = pend_q & en_q;

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !wdata_i[0] && !fire_i) |=> !pend_q);
  // R9
  fire_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pend_q);
  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wr_stat) |=> pend_q);
  // R6
  fire_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> en_q);
endmodule

// File: rtl/core_evt_timer.sv
module core_evt_timer
  import ptim_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       idx_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] load_val;
  logic             en, load_we, fire;

  ptim_free_cnt #(.CNT_W(CNT_W)) u_free (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ptim_evt_unit #(.CNT_W(CNT_W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .load_we_i  (load_we),
    .load_val_i (load_val),
    .fire_o     (fire)
  );

  ptim_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .tick_i     (tick),
    .fire_i     (fire),
    .en_o       (en),
    .load_we_o  (load_we),
    .load_val_o (load_val),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fire) || $past(we_i && idx_i == IDX_CTRL));
endmodule

// File: tb/core_evt_timer_tb_top.sv
`timescale 1ns/1ps
module core_evt_timer_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   idx = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;
  logic [W-1:0] fc;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  core_evt_timer #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // tick model: one step per clock out of reset, modulo 2^W
  always @(posedge clk or negedge rst_n)
    if (!rst_n) fc <= '0;
    else        fc <= fc + 1'b1;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [W-1:0] d);
    @(negedge clk);
    idx = i; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, input logic [W-1:0] exp, input string tag);
    idx = i;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick_chk(input string tag);
    idx = 3'd3;
    #1;
    chk(tag, rdata, fc);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, '0, "R1 ctrl");
    rd(3'd1, '0, "R1 stat");
    rd(3'd6, '0, "R1 load");
    chk("R1 irq", irq, 0);
    tick_chk("R1 tick follows reset");

    // R2 unused indices ignore writes and read zero
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i == 1 || i == 3 || i == 6) continue;
      wr(i[2:0], 8'hA5);
    end
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i == 1 || i == 3 || i == 6) continue;
      rd(i[2:0], '0, "R2 unused read");
    end
    rd(3'd0, '0, "R2 ctrl untouched");
    rd(3'd6, '0, "R2 load untouched");
    chk("R2 irq", irq, 0);

    // R6 load while disabled: stored, no event even after enable
    wr(3'd6, 8'd5);
    rd(3'd6, 8'd5, "R6 load stored");
    wr(3'd0, 8'd1);
    rd(3'd0, 8'd1, "R2 ctrl bit0");
    wait_n(12);
    rd(3'd1, '0, "R6 no event");
    chk("R6 irq", irq, 0);

    // R4 sweep of delta
    for (int d = 1; d <= 40; d++) begin
      wr(3'd6, d[W-1:0]);
      wait_n(d - 1);
      chk("R4 early", irq, 0);
      wait_n(1);
      chk("R4 on time", irq, 1);
      rd(3'd1, 8'd1, "R4 status");
      tick_chk("R3 tick in sweep");
      wr(3'd1, 8'd0);
      chk("R9 cleared", irq, 0);
    end

    // R4 largest delta
    wr(3'd6, MAXV);
    wait_n(int'(MAXV) - 1);
    chk("R4 max early", irq, 0);
    wait_n(1);
    chk("R4 max on time", irq, 1);
    // R9 write one ignored
    wr(3'd1, 8'd1);
    chk("R9 write one ignored", irq, 1);
    // R8 mask by enable, pending survives
    wr(3'd0, 8'd0);
    chk("R8 masked", irq, 0);
    rd(3'd1, 8'd1, "R8 pending kept");
    wr(3'd0, 8'd1);
    chk("R8 unmasked", irq, 1);
    wr(3'd1, 8'd0);
    chk("R9 clear", irq, 0);

    // R10 no re-fire
    wait_n(300);
    chk("R10 quiet", irq, 0);
    rd(3'd1, '0, "R10 status");

    // R5 reload mid countdown
    wr(3'd6, 8'd10);
    wait_n(4);
    wr(3'd6, 8'd3);
    wait_n(2);
    chk("R5 early", irq, 0);
    wait_n(1);
    chk("R5 on time", irq, 1);
    rd(3'd6, 8'd3, "R5 readback");
    wr(3'd1, 8'd0);

    // R6 disable cancels countdown
    wr(3'd6, 8'd10);
    wait_n(3);
    wr(3'd0, 8'd0);
    wr(3'd0, 8'd1);
    wait_n(20);
    chk("R6 cancelled", irq, 0);
    rd(3'd1, '0, "R6 cancelled status");

    // R7 zero delta cancels
    wr(3'd6, 8'd6);
    wait_n(2);
    wr(3'd6, 8'd0);
    wait_n(20);
    chk("R7 cancelled", irq, 0);
    rd(3'd6, '0, "R7 readback");

    // R9 expiry wins over clear on the same edge
    wr(3'd6, 8'd3);
    wait_n(1);
    wr(3'd1, 8'd0);
    rd(3'd1, 8'd1, "R9 expiry wins");
    chk("R9 irq after tie", irq, 1);
    wr(3'd1, 8'd0);

    // R3 writes to tick ignored, wrap covered by elapsed cycles
    wr(3'd3, 8'h00);
    tick_chk("R3 write ignored");
    wait_n(257);
    tick_chk("R3 after wrap");
    wr(3'd0, 8'd0);
    tick_chk("R3 tick while disabled");

    finish_run();
  end
endmodule